// File: doc/BRIEF.md
# Multi-Cycle Unit Issue Interlock

This block sits at the decode stage of an in-order pipeline that has an integer path, a memory path and two pipelined floating-point units (multiply and add). For every architectural register it keeps a countdown of the cycles left before a pending result can reach a consumer over the forwarding network. Each cycle it looks at the decoded instruction and grants issue only when every enabled source can be forwarded in time and the target unit can take a new operation. If it does not grant issue, the instruction stays in decode and a bubble goes downstream.

Issue is granted in the same cycle the instruction is presented, so the check is combinational. The countdowns and the per-unit initiation counters change on the following clock edge. Unit latencies, the store-data slack and the initiation intervals are parameters. The default values model a multiply with 6 extra cycles, an add with 3, a load with 1 and integer operations with none.

Top module: `isi_issue_ctrl`

## Requirements
- R1: After reset every register reads as ready and every unit is free. A valid instruction presented in the first cycle after reset is granted with no stall.
- R2: An integer operation (unit code 0) has latency 0. A dependent instruction presented in the next cycle issues without a stall.
- R3: A load (unit code 1) has latency LAT_LOAD (default 1). A dependent presented right after it stalls for exactly LAT_LOAD cycles.
- R4: A floating-point multiply (unit code 3) has latency LAT_MUL (default 6). A dependent presented right after it stalls for exactly LAT_MUL cycles.
- R5: A floating-point add (unit code 4) has latency LAT_ADD (default 3). A dependent presented right after it stalls for exactly LAT_ADD cycles.
- R6: For a store (unit code 2), source B carries the data and may be granted when at most STORE_SLACK (default 1) cycles remain on its countdown. Source A is the address and needs a countdown of zero.
- R7: The multiply unit and the add unit each take a new operation only once II_MUL or II_ADD cycles (default 1) have passed since their last issue. With an interval of 1, back-to-back issue is allowed.
- R8: stall_o equals valid_i and not issue_o. When valid_i is low, or an instruction is stalled, no countdown is written.
- R9: fwd_ready_o bit 0 (source A) and bit 1 (source B) are 1 when that source is disabled or can be forwarded in time. Issue implies both bits are 1.
- R10: An issue that writes a register reloads that register's countdown with the issuing unit's latency. This replaces any value still pending.
- R11: An instruction that names the same register as source and destination sees the countdown from before its own write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | A decoded instruction is present |
| unit_i | input | 3 | Unit class: 0 int, 1 load, 2 store, 3 fmul, 4 fadd; other codes are treated as int |
| src_a_i | input | RW | Source A register index (store address) |
| src_a_en_i | input | 1 | Source A is used |
| src_b_i | input | RW | Source B register index (store data) |
| src_b_en_i | input | 1 | Source B is used |
| dst_i | input | RW | Destination register index |
| dst_en_i | input | 1 | Instruction writes dst_i |
| issue_o | output | 1 | Instruction is granted this cycle |
| stall_o | output | 1 | Instruction is held in decode and a bubble is sent |
| fwd_ready_o | output | 2 | Per-source forwarding readiness, bit 0 = A, bit 1 = B |

## Verification
The bench measures exact stall counts behind each latency class. An off-by-one countdown shows up as one bubble too many or too few. It checks the relaxed store-data threshold against the strict store-address threshold. A design that used one threshold for both would stall a store one cycle too long, or issue an address one cycle too early. A second instance with intervals above 1 shows whether a unit turns away back-to-back operations for the correct number of cycles. Further scenarios cover three cases: a destination rewritten by a shorter operation, a register that is both source and destination, and instructions that are invalid or stalled. A design that wrote the scoreboard in any of those cycles would create or hide stalls.

// File: rtl/isi_pkg.sv
package isi_pkg;
  localparam int NSRC = 2;

  typedef enum logic [2:0] {
    UNIT_INT   = 3'd0,
    UNIT_LOAD  = 3'd1,
    UNIT_STORE = 3'd2,
    UNIT_FMUL  = 3'd3,
    UNIT_FADD  = 3'd4
  } unit_e;
endpackage

// File: rtl/isi_scoreboard.sv
module isi_scoreboard
  import isi_pkg::*;
#(
  parameter int NREG = 32,
  parameter int CW   = 3,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [RW-1:0] wr_idx_i,
  input  logic [CW-1:0] wr_val_i,
  input  logic [RW-1:0] rd_idx_i [NSRC],
  output logic [CW-1:0] rd_cnt_o [NSRC]
);
  logic [CW-1:0] cnt_q [NREG];

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic hit;
    assign hit = wr_en_i && (wr_idx_i == RW'(r));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                cnt_q[r] <= '0;
      else if (hit)               cnt_q[r] <= wr_val_i;
      else if (cnt_q[r] != '0)    cnt_q[r] <= cnt_q[r] - 1'b1;
    end

    AST_CNT_DECAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q[r] != '0 && !hit) |=> cnt_q[r] == $past(cnt_q[r]) - 1'b1); // R4
    AST_CNT_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit |=> cnt_q[r] == $past(wr_val_i)); // R10
  end

  for (genvar k = 0; k < NSRC; k++) begin : g_rd
    assign rd_cnt_o[k] = cnt_q[rd_idx_i[k]];
  end
endmodule

// File: rtl/isi_unit_gate.sv
module isi_unit_gate
  import isi_pkg::*;
#(
  parameter int II_MUL = 1,
  parameter int II_ADD = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] unit_i,
  input  logic       issue_i,
  output logic       free_o
);
  localparam int NFP = 2;
  logic [NFP-1:0] busy;
  logic [NFP-1:0] sel;

  assign sel[0] = (unit_i == UNIT_FMUL);
  assign sel[1] = (unit_i == UNIT_FADD);

  for (genvar g = 0; g < NFP; g++) begin : g_fp
    localparam int II = (g == 0) ? II_MUL : II_ADD;
    if (II > 1) begin : g_cnt
      localparam int IW = $clog2(II);
      logic [IW-1:0] gap_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                gap_q <= '0;
        else if (issue_i && sel[g]) gap_q <= IW'(II - 1);
        else if (gap_q != '0)       gap_q <= gap_q - 1'b1;
      end
      assign busy[g] = (gap_q != '0);

      AST_II_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (issue_i && sel[g]) |=> busy[g]); // R7
    end else begin : g_pipe
      assign busy[g] = 1'b0;
    end
  end

  assign free_o = ~|(busy & sel);
endmodule

// File: rtl/isi_src_check.sv
module isi_src_check #(
  parameter int CW = 3
) (
  input  logic          en_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] thr_i,
  output logic          ready_o
);
  assign ready_o = !en_i || (cnt_i <= thr_i);
endmodule

// File: rtl/isi_issue_ctrl.sv
module isi_issue_ctrl
  import isi_pkg::*;
#(
  parameter int NREG        = 32,
  parameter int LAT_LOAD    = 1,
  parameter int LAT_MUL     = 6,
  parameter int LAT_ADD     = 3,
  parameter int STORE_SLACK = 1,
  parameter int II_MUL      = 1,
  parameter int II_ADD      = 1,
  localparam int RW         = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [2:0]    unit_i,
  input  logic [RW-1:0] src_a_i,
  input  logic          src_a_en_i,
  input  logic [RW-1:0] src_b_i,
  input  logic          src_b_en_i,
  input  logic [RW-1:0] dst_i,
  input  logic          dst_en_i,
  output logic          issue_o,
  output logic          stall_o,
  output logic [1:0]    fwd_ready_o
);
  localparam int MAX_A   = (LAT_MUL > LAT_ADD) ? LAT_MUL : LAT_ADD;
  localparam int MAX_B   = (LAT_LOAD > STORE_SLACK) ? LAT_LOAD : STORE_SLACK;
  localparam int MAX_LAT = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW      = $clog2(MAX_LAT + 1) < 1 ? 1 : $clog2(MAX_LAT + 1);

  logic [RW-1:0] rd_idx [NSRC];
  logic [CW-1:0] rd_cnt [NSRC];
  logic [CW-1:0] thr    [NSRC];
  logic          src_en [NSRC];
  logic [NSRC-1:0] src_rdy;
  logic [CW-1:0] lat;
  logic          unit_free;
  logic          is_store;

  assign is_store  = (unit_i == UNIT_STORE);
  assign rd_idx[0] = src_a_i;
  assign rd_idx[1] = src_b_i;
  assign src_en[0] = src_a_en_i;
  assign src_en[1] = src_b_en_i;
  assign thr[0]    = '0;
  assign thr[1]    = is_store ? CW'(STORE_SLACK) : '0;

  always_comb begin
    case (unit_i)
      UNIT_LOAD: lat = CW'(LAT_LOAD);
      UNIT_FMUL: lat = CW'(LAT_MUL);
      UNIT_FADD: lat = CW'(LAT_ADD);
      default:   lat = '0;
    endcase
  end

  isi_scoreboard #(.NREG(NREG), .CW(CW)) u_sb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (issue_o && dst_en_i),
    .wr_idx_i (dst_i),
    .wr_val_i (lat),
    .rd_idx_i (rd_idx),
    .rd_cnt_o (rd_cnt)
  );

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    isi_src_check #(.CW(CW)) u_chk (
      .en_i    (src_en[k]),
      .cnt_i   (rd_cnt[k]),
      .thr_i   (thr[k]),
      .ready_o (src_rdy[k])
    );
  end

  isi_unit_gate #(.II_MUL(II_MUL), .II_ADD(II_ADD)) u_gate (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .unit_i  (unit_i),
    .issue_i (issue_o),
    .free_o  (unit_free)
  );

  assign fwd_ready_o = src_rdy;
  assign issue_o     = valid_i && (&src_rdy) && unit_free;
  assign stall_o     = valid_i && !issue_o;

  AST_ONE_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> (issue_o ^ stall_o)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> !(issue_o || stall_o)); // R8
  AST_ISSUE_FWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o |-> fwd_ready_o == 2'b11); // R9
  AST_INT_NO_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o && dst_en_i && unit_i == UNIT_INT) |=>
      (!src_a_en_i || src_a_i != $past(dst_i) || fwd_ready_o[0])); // R2
endmodule

// File: tb/tb_isi_issue_ctrl.sv
module tb_isi_issue_ctrl;
  localparam int NREG = 32, LAT_LOAD = 1, LAT_MUL = 6, LAT_ADD = 3, SLACK = 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic       valid = 1'b0, sa_en = 1'b0, sb_en = 1'b0, dd_en = 1'b0;
  logic [2:0] unit = 3'd0;
  logic [4:0] sa = '0, sb = '0, dd = '0;
  logic       issue, stall, issue_ii, stall_ii;
  logic [1:0] fwd, fwd_ii;

  isi_issue_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid), .unit_i(unit),
    .src_a_i(sa), .src_a_en_i(sa_en), .src_b_i(sb), .src_b_en_i(sb_en),
    .dst_i(dd), .dst_en_i(dd_en), .issue_o(issue), .stall_o(stall), .fwd_ready_o(fwd)
  );

  isi_issue_ctrl #(.II_MUL(3), .II_ADD(2)) dut_ii (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid), .unit_i(unit),
    .src_a_i(sa), .src_a_en_i(sa_en), .src_b_i(sb), .src_b_en_i(sb_en),
    .dst_i(dd), .dst_en_i(dd_en), .issue_o(issue_ii), .stall_o(stall_ii), .fwd_ready_o(fwd_ii)
  );

  int cnt [NREG];
  int checks = 0, errors = 0;
  bit exp_issue;

  function automatic int lat_of(logic [2:0] u);
    case (u)
      3'd1: return LAT_LOAD;
      3'd3: return LAT_MUL;
      3'd4: return LAT_ADD;
      default: return 0;
    endcase
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // reference step: compare before the edge, then advance the model
  task automatic cycle(string tag);
    bit ra, rb, es;
    #1;
    ra = !sa_en || cnt[sa] <= 0;
    rb = !sb_en || cnt[sb] <= ((unit == 3'd2) ? SLACK : 0);
    exp_issue = valid && ra && rb;
    es = valid && !exp_issue;
    check(issue === exp_issue, tag, "issue", int'(issue), int'(exp_issue));
    check(stall === es, tag, "stall", int'(stall), int'(es));
    check(fwd === {rb, ra}, tag, "fwd_ready", int'(fwd), int'({rb, ra}));
    @(posedge clk);
    for (int r = 0; r < NREG; r++) if (cnt[r] > 0) cnt[r]--;
    if (exp_issue && dd_en) cnt[dd] = lat_of(unit);
    @(negedge clk);
  endtask

  task automatic drive(logic v, logic [2:0] u, logic [4:0] a, logic ae,
                       logic [4:0] b, logic be, logic [4:0] d, logic de);
    valid = v; unit = u; sa = a; sa_en = ae; sb = b; sb_en = be; dd = d; dd_en = de;
  endtask

  task automatic instr(string tag, logic [2:0] u, logic [4:0] a, logic ae,
                       logic [4:0] b, logic be, logic [4:0] d, logic de, int exp_st);
    int st = 0;
    bit done = 0;
    drive(1'b1, u, a, ae, b, be, d, de);
    for (int i = 0; i < 40 && !done; i++) begin
      cycle(tag);
      if (exp_issue) done = 1; else st++;
    end
    check(st == exp_st, tag, "stall cycles", st, exp_st);
  endtask

  task automatic idle(int n);
    valid = 1'b0;
    repeat (n) cycle("R8");
  endtask

  task automatic ii_probe(bit exp);
    #1 check(issue_ii === exp, "R7", "ii issue", int'(issue_ii), int'(exp));
    cycle("R7");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog R1: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int r = 0; r < NREG; r++) cnt[r] = 0;
    repeat (3) @(negedge clk);
    #1 check(issue === 1'b0 && stall === 1'b0, "R1", "outputs in reset",
             int'({issue, stall}), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    // units: 0 int 1 load 2 store 3 fmul 4 fadd
    instr("R1", 3'd3, 5'd2, 1, 5'd3, 1, 5'd1, 1, 0);
    instr("R4", 3'd4, 5'd1, 1, 5'd1, 1, 5'd4, 1, LAT_MUL);
    instr("R5", 3'd4, 5'd4, 1, 5'd6, 1, 5'd5, 1, LAT_ADD);
    instr("R6", 3'd2, 5'd7, 1, 5'd5, 1, 5'd0, 0, LAT_ADD - SLACK);
    idle(8);
    instr("R3", 3'd1, 5'd9, 1, 5'd0, 0, 5'd8, 1, 0);
    instr("R3", 3'd0, 5'd8, 1, 5'd0, 0, 5'd10, 1, LAT_LOAD);
    instr("R2", 3'd0, 5'd10, 1, 5'd0, 0, 5'd11, 1, 0);
    instr("R6", 3'd4, 5'd2, 1, 5'd3, 1, 5'd12, 1, 0);
    drive(1'b1, 3'd2, 5'd12, 1, 5'd0, 1, 5'd0, 0);
    #1 check(fwd === 2'b10, "R9", "store fwd_ready", int'(fwd), 2);
    instr("R6", 3'd2, 5'd12, 1, 5'd0, 1, 5'd0, 0, LAT_ADD);
    idle(5);
    // R7: interval 3 on multiply, 2 on add in dut_ii; dut stays back-to-back
    drive(1'b1, 3'd3, 5'd2, 1, 5'd3, 1, 5'd13, 1);
    ii_probe(1'b1); ii_probe(1'b0); ii_probe(1'b0); ii_probe(1'b1);
    idle(4);
    drive(1'b1, 3'd4, 5'd2, 1, 5'd3, 1, 5'd14, 1);
    ii_probe(1'b1); ii_probe(1'b0); ii_probe(1'b1);
    idle(8);
    // R8: invalid instruction must not write its destination
    drive(1'b0, 3'd3, 5'd0, 0, 5'd0, 0, 5'd2, 1);
    cycle("R8");
    instr("R8", 3'd0, 5'd2, 1, 5'd0, 0, 5'd20, 1, 0);
    // R10: shorter op to same destination replaces the pending countdown
    instr("R10", 3'd3, 5'd2, 1, 5'd3, 1, 5'd15, 1, 0);
    instr("R10", 3'd0, 5'd0, 0, 5'd0, 0, 5'd15, 1, 0);
    instr("R10", 3'd0, 5'd15, 1, 5'd0, 0, 5'd17, 1, 0);
    // R11: source equal to destination sees the prior countdown
    instr("R11", 3'd3, 5'd2, 1, 5'd3, 1, 5'd16, 1, 0);
    instr("R11", 3'd4, 5'd16, 1, 5'd0, 0, 5'd16, 1, LAT_MUL);
    instr("R11", 3'd0, 5'd0, 0, 5'd16, 1, 5'd18, 1, LAT_ADD);
    idle(3);
    summary();
    $finish;
  end
endmodule